// File: doc/BRIEF.md
# Byte-Synchronous Serial Transmit Engine

This block turns host-written characters into a serial bit stream for byte-synchronous links, one bit per clock, least significant bit first. The host loads one character at a time into a single-entry holding buffer. At each character boundary the engine moves the buffered character, formatted to the programmed length with an optional parity bit, into its shift register. When the buffer is empty, the engine fills the line with a programmable sync pattern.

When the buffer and the shift register are both empty and the end-of-message latch is clear, the engine sends the 16-bit check value from an external CRC unit. It then sets the latch and pulses an interrupt. The CRC arithmetic is outside this block. The engine gives the CRC unit one bit strobe per transmitted data bit, for characters that were marked for inclusion, and a preset pulse when the host asks for one. Turning the transmitter off never cuts a character short. The line returns to mark once the shift register has drained.

Top module: `bsync_tx`

## Requirements
- R1: After synchronous reset: `txd` is 1, `buf_empty` is 1, `eom_flag` is 1, `stat_irq` and `crc_preset` are 0, the configuration is all zeros and both sync bytes are zero.
- R2: While `tx_en` is 0 and no character is in progress, `txd` stays at 1 and nothing is loaded.
- R3: Configuration bits [1:0] set the character length: 01 gives 6 bits, 10 gives 7 bits, 11 gives 8 bits. Only the low bits of the buffered byte are sent, LSB first, and the upper bits are ignored.
- R4: With configuration bits [1:0] = 00, let k be the number of consecutive ones from bit 7 downward, counted within bits 7..4 (so 0 to 4). The engine sends the low 5-k bits of the byte.
- R5: Configuration bit [2] appends one parity bit after the data bits. With bit [3] = 1 the parity is even (the total count of ones is even), and with bit [3] = 0 it is odd.
- R6: Sync fill is chosen by configuration bits [5:4]. With 00 or 11 the engine sends `sync_wdata[7:0]` (8 bits). With 01 it sends `sync_wdata[15:0]` (16 bits, low byte first). With 10 it sends `sync_wdata[5:0]` (6 bits).
- R7: On underrun with `eom_flag` at 0, the engine sends the 16 bits of `crc_rem`, LSB first, as sampled at the load edge. `eom_flag` rises on that same edge and `stat_irq` is high for exactly that one cycle.
- R8: On underrun with `eom_flag` at 1, the engine sends sync fill. `cmd_code` 10 with `cmd_wr` clears the latch. If a CRC load happens on the same edge, the set wins.
- R9: Configuration bit [6] is sampled when a character moves from the buffer to the shift register. For an included character, `crc_feed` is 1 together with `crc_din` equal to the bit that `txd` takes at the next edge, for every bit of that character including parity. Sync and CRC bits are never fed.
- R10: `cmd_code` 01 with `cmd_wr` gives a one-cycle `crc_preset` pulse in the following cycle.
- R11: When `tx_en` falls in the middle of a data, sync or CRC character, that character is completed bit by bit before `txd` returns to 1.
- R12: `buf_empty` rises on the edge that moves the buffer into the shift register. A `data_wr` while the buffer is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmitter enable, checked at character boundaries |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration: [1:0] length, [2] parity on, [3] even, [5:4] sync mode, [6] CRC include |
| sync_wr | input | 1 | Sync pattern write strobe |
| sync_wdata | input | 16 | Sync pattern, low byte in [7:0] |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 2 | 01 preset CRC, 10 clear end-of-message latch, others no effect |
| data_wr | input | 1 | Character write strobe |
| data_wdata | input | 8 | Character, right-justified |
| crc_rem | input | 16 | Current value from the external CRC unit |
| txd | output | 1 | Serial data, mark is 1 |
| crc_feed | output | 1 | Bit strobe for the CRC unit |
| crc_din | output | 1 | Bit for the CRC unit, valid with crc_feed |
| crc_preset | output | 1 | Preset pulse for the CRC unit |
| buf_empty | output | 1 | Holding buffer can take a character |
| eom_flag | output | 1 | End-of-message latch |
| stat_irq | output | 1 | One-cycle pulse when the CRC is started |

## Verification
The embedded properties assume that every host strobe is a single-cycle pulse sampled on the rising edge, that `crc_rem` is valid whenever the engine may load it, and that `tx_en` may change on any cycle. The stimulus drives every strobe for exactly one cycle from the falling edge. It normally waits for the buffer to empty before writing a character, except for one deliberate back-to-back write that shows the drop rule. It also toggles `tx_en` inside data and sync characters to exercise the completion rule. The CRC input comes from a small bench-side register that follows the engine's feed and preset outputs, so the appended check value depends on the exact bits the engine reported.

// File: rtl/bsync_tx_pkg.sv
`timescale 1ns/1ps
// Shared widths, field layout and enumerations for the sync transmit engine.
// Assumes a byte-wide host data path and a 16-bit check value.
package bsync_tx_pkg;
    parameter int BYTE_W  = 8;                         // buffered character width
    parameter int CRC_W   = 16;                        // check value width
    parameter int MIN_LEN = 5;                         // shortest fixed character length
    parameter int SHORT_W = 6;                         // short sync pattern width
    localparam int SYNC_W  = 2 * BYTE_W;               // two sync bytes
    localparam int SR_W    = (CRC_W > SYNC_W) ? CRC_W : SYNC_W;
    localparam int CNT_W   = $clog2(SR_W + 1);
    localparam int PREFIX_W = BYTE_W - MIN_LEN + 1;    // bits scanned for the short-length prefix
    localparam int CFG_W   = 7;

    typedef enum logic [1:0] {K_IDLE, K_SYNC, K_DATA, K_CRC} kind_t;
    typedef enum logic [1:0] {SY_BYTE = 2'b00, SY_PAIR = 2'b01, SY_SHORT = 2'b10, SY_BYTE2 = 2'b11} sync_mode_t;

    localparam logic [1:0] CMD_PRESET  = 2'b01;
    localparam logic [1:0] CMD_EOM_CLR = 2'b10;

    typedef struct packed {
        logic       crc_incl;   // [6]
        sync_mode_t sync_mode;  // [5:4]
        logic       par_even;   // [3]
        logic       par_en;     // [2]
        logic [1:0] char_len;   // [1:0]
    } cfg_t;
endpackage

// File: rtl/bsync_tx_regs.sv
`timescale 1ns/1ps
// Host-side registers: configuration, sync pattern and command decode.
// Assumes strobes are single-cycle; commands other than the two defined codes do nothing.
module bsync_tx_regs
    import bsync_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              sync_wr,
    input  logic [SYNC_W-1:0] sync_wdata,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_code,
    output cfg_t              cfg,
    output logic [SYNC_W-1:0] sync_val,
    output logic              crc_preset,
    output logic              eom_clr
);
    cfg_t              cfg_q;
    logic [SYNC_W-1:0] sync_q;
    logic              preset_q;

    // Hold configuration, sync pattern and the registered preset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            sync_q   <= '0;
            preset_q <= 1'b0;
        end else begin
            if (cfg_wr)  cfg_q  <= cfg_t'(cfg_wdata);
            if (sync_wr) sync_q <= sync_wdata;
            preset_q <= cmd_wr && (cmd_code == CMD_PRESET);
        end
    end

    assign cfg        = cfg_q;
    assign sync_val   = sync_q;
    assign crc_preset = preset_q;
    assign eom_clr    = cmd_wr && (cmd_code == CMD_EOM_CLR);

    p_preset_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_code == CMD_PRESET) |=> crc_preset);
endmodule

// File: rtl/bsync_tx_buf.sv
`timescale 1ns/1ps
// Single-entry holding buffer between the host and the shift register.
// Assumes take is only raised while the buffer is full; writes to a full buffer are dropped.
module bsync_tx_buf
    import bsync_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [BYTE_W-1:0] rdata
);
    logic              full_q;
    logic [BYTE_W-1:0] byte_q;

    // Accept a character when empty; release it on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            byte_q <= '0;
        end else begin
            if (take) full_q <= 1'b0;
            if (wr && !full_q) begin
                full_q <= 1'b1;
                byte_q <= wdata;
            end
        end
    end

    assign full  = full_q;
    assign rdata = byte_q;

    p_take_needs_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full_q);
    p_drop_when_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr) |=> $stable(byte_q));
    p_take_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !full_q);
endmodule

// File: rtl/bsync_tx_fmt.sv
`timescale 1ns/1ps
// Purely combinational formatting of the next data word and the sync word.
// Assumes right-justified data; result words are LSB-first with their bit counts.
module bsync_tx_fmt
    import bsync_tx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  cfg_t              cfg,
    input  logic [SYNC_W-1:0] sync_val,
    output logic [SR_W-1:0]   data_word,
    output logic [CNT_W-1:0]  data_len,
    output logic [SR_W-1:0]   sync_word,
    output logic [CNT_W-1:0]  sync_len
);
    logic [CNT_W-1:0] lead_ones;
    logic [CNT_W-1:0] n_bits;
    logic             run;
    logic             ones_odd;

    // Count the leading ones of the prefix used by the shortest length code.
    always_comb begin
        lead_ones = '0;
        run       = 1'b1;
        for (int i = BYTE_W - 1; i >= BYTE_W - PREFIX_W; i--) begin
            if (run && byte_in[i]) lead_ones = lead_ones + CNT_W'(1);
            else                   run = 1'b0;
        end
    end

    // Build the data word: masked data bits, then the optional parity bit.
    always_comb begin
        if (cfg.char_len == 2'd0) n_bits = CNT_W'(MIN_LEN) - lead_ones;
        else                      n_bits = CNT_W'(MIN_LEN) + CNT_W'(cfg.char_len);
        data_word = '0;
        ones_odd  = 1'b0;
        for (int i = 0; i < BYTE_W; i++) begin
            if (CNT_W'(i) < n_bits) begin
                data_word[i] = byte_in[i];
                ones_odd     = ones_odd ^ byte_in[i];
            end
        end
        if (cfg.par_en) data_word[n_bits] = cfg.par_even ? ones_odd : ~ones_odd;
        data_len = n_bits + CNT_W'(cfg.par_en);
    end

    // Select the sync pattern and its length.
    always_comb begin
        unique case (cfg.sync_mode)
            SY_PAIR: begin
                sync_word = SR_W'(sync_val);
                sync_len  = CNT_W'(SYNC_W);
            end
            SY_SHORT: begin
                sync_word = SR_W'(sync_val[SHORT_W-1:0]);
                sync_len  = CNT_W'(SHORT_W);
            end
            default: begin
                sync_word = SR_W'(sync_val[BYTE_W-1:0]);
                sync_len  = CNT_W'(BYTE_W);
            end
        endcase
    end

    p_len_nonzero_r4: assert final (n_bits != '0 && n_bits <= CNT_W'(BYTE_W));
endmodule

// File: rtl/bsync_tx_shift.sv
`timescale 1ns/1ps
// Shift register and character sequencer: picks data, CRC, sync or idle at each
// boundary, runs the end-of-message latch and drives the CRC unit's bit strobe.
// Assumes crc_rem already contains every fed bit at the edge after the last one.
module bsync_tx_shift
    import bsync_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             buf_full,
    input  logic [SR_W-1:0]  data_word,
    input  logic [CNT_W-1:0] data_len,
    input  logic             crc_incl,
    input  logic [SR_W-1:0]  sync_word,
    input  logic [CNT_W-1:0] sync_len,
    input  logic [CRC_W-1:0] crc_rem,
    input  logic             eom_clr,
    output logic             take,
    output logic             txd,
    output logic             crc_feed,
    output logic             crc_din,
    output logic             eom,
    output logic             irq
);
    kind_t            kind_q, ld_kind;
    logic [SR_W-1:0]  sr_q, ld_word;
    logic [CNT_W-1:0] cnt_q, ld_len;
    logic             incl_q, txd_q, eom_q, irq_q;
    logic             shift_empty, next_bit;

    // Decide what to load when the shift register runs dry.
    always_comb begin
        ld_kind = K_IDLE;
        ld_word = '1;
        ld_len  = '0;
        if (tx_en) begin
            if (buf_full) begin
                ld_kind = K_DATA;
                ld_word = data_word;
                ld_len  = data_len;
            end else if (!eom_q) begin
                ld_kind = K_CRC;
                ld_word = SR_W'(crc_rem);
                ld_len  = CNT_W'(CRC_W);
            end else begin
                ld_kind = K_SYNC;
                ld_word = sync_word;
                ld_len  = sync_len;
            end
        end
    end

    assign shift_empty = (cnt_q == '0);
    assign next_bit    = shift_empty ? ld_word[0] : sr_q[0];
    assign take        = shift_empty && (ld_kind == K_DATA);
    assign crc_feed    = shift_empty ? (take && crc_incl) : ((kind_q == K_DATA) && incl_q);
    assign crc_din     = next_bit;

    // Shift one bit per clock, load at boundaries, update latch and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_IDLE;
            sr_q   <= '0;
            cnt_q  <= '0;
            incl_q <= 1'b0;
            txd_q  <= 1'b1;
            eom_q  <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            txd_q <= next_bit;
            irq_q <= 1'b0;
            if (eom_clr) eom_q <= 1'b0;
            if (shift_empty) begin
                kind_q <= ld_kind;
                sr_q   <= ld_word >> 1;
                cnt_q  <= (ld_kind == K_IDLE) ? '0 : ld_len - CNT_W'(1);
                if (take) incl_q <= crc_incl;
                if (ld_kind == K_CRC) begin
                    eom_q <= 1'b1;
                    irq_q <= 1'b1;
                end
            end else begin
                sr_q  <= sr_q >> 1;
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    assign txd = txd_q;
    assign eom = eom_q;
    assign irq = irq_q;

    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_empty && !tx_en) |=> (txd_q && kind_q == K_IDLE));
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    p_eom_rise_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eom_q) |-> irq_q);
    p_no_feed_crc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_empty && kind_q != K_DATA) |-> !crc_feed);
    p_char_completes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_empty |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/bsync_tx.sv
`timescale 1ns/1ps
// Top of the byte-synchronous transmit engine: host registers, holding buffer,
// formatter and sequencer. Assumes an external CRC unit driven by crc_feed/crc_din.
module bsync_tx
    import bsync_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              sync_wr,
    input  logic [SYNC_W-1:0] sync_wdata,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_code,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] data_wdata,
    input  logic [CRC_W-1:0]  crc_rem,
    output logic              txd,
    output logic              crc_feed,
    output logic              crc_din,
    output logic              crc_preset,
    output logic              buf_empty,
    output logic              eom_flag,
    output logic              stat_irq
);
    cfg_t              cfg;
    logic [SYNC_W-1:0] sync_val;
    logic              eom_clr, take, full;
    logic [BYTE_W-1:0] buf_byte;
    logic [SR_W-1:0]   data_word, sync_word;
    logic [CNT_W-1:0]  data_len, sync_len;

    bsync_tx_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sync_wr(sync_wr), .sync_wdata(sync_wdata),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .cfg(cfg), .sync_val(sync_val),
        .crc_preset(crc_preset), .eom_clr(eom_clr)
    );

    bsync_tx_buf u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr(data_wr), .wdata(data_wdata), .take(take),
        .full(full), .rdata(buf_byte)
    );

    bsync_tx_fmt u_fmt (
        .byte_in(buf_byte), .cfg(cfg), .sync_val(sync_val),
        .data_word(data_word), .data_len(data_len),
        .sync_word(sync_word), .sync_len(sync_len)
    );

    bsync_tx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .buf_full(full), .data_word(data_word), .data_len(data_len),
        .crc_incl(cfg.crc_incl), .sync_word(sync_word), .sync_len(sync_len),
        .crc_rem(crc_rem), .eom_clr(eom_clr),
        .take(take), .txd(txd), .crc_feed(crc_feed), .crc_din(crc_din),
        .eom(eom_flag), .irq(stat_irq)
    );

    assign buf_empty = !full;

    p_empty_after_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !data_wr) |=> buf_empty);
endmodule

// File: tb/bsync_tx_tb.sv
`timescale 1ns/1ps
// Bench: behavioural bit-queue model of the engine, compared every cycle.
module bsync_tx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic        sync_wr = 1'b0;
    logic [15:0] sync_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_code = '0;
    logic        data_wr = 1'b0;
    logic [7:0]  data_wdata = '0;
    logic [15:0] crc_rem = '0;
    logic        txd, crc_feed, crc_din, crc_preset, buf_empty, eom_flag, stat_irq;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    started = 0;
    bit    done = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    bsync_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .sync_wr(sync_wr), .sync_wdata(sync_wdata),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .data_wr(data_wr), .data_wdata(data_wdata),
        .crc_rem(crc_rem),
        .txd(txd), .crc_feed(crc_feed), .crc_din(crc_din), .crc_preset(crc_preset),
        .buf_empty(buf_empty), .eom_flag(eom_flag), .stat_irq(stat_irq)
    );

    // ---------------- reference model ----------------
    bit          mq[$];
    int          m_kind;          // 0 idle, 1 sync, 2 data, 3 crc
    bit          m_incl, m_full, m_eom, m_irq, m_txd, m_preset;
    logic [7:0]  m_byte;
    logic [6:0]  m_cfg;
    logic [15:0] m_sync;

    function automatic int mk_data(input logic [7:0] b, input logic [6:0] c, output logic [15:0] w);
        int k = 0;
        int n;
        int ones = 0;
        while (k < 4 && b[7-k]) k++;
        n = (c[1:0] == 2'd0) ? 5 - k : 5 + int'(c[1:0]);
        w = '0;
        for (int i = 0; i < n; i++) begin
            w[i] = b[i];
            ones += int'(b[i]);
        end
        if (c[2]) begin
            w[n] = c[3] ? (ones % 2 == 1) : (ones % 2 == 0);
            n++;
        end
        return n;
    endfunction

    function automatic int mk_sync(input logic [6:0] c, input logic [15:0] s, output logic [15:0] w);
        if (c[5:4] == 2'b01) begin w = s; return 16; end
        if (c[5:4] == 2'b10) begin w = {10'b0, s[5:0]}; return 6; end
        w = {8'b0, s[7:0]};
        return 8;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] r, input logic b);
        logic fb = b ^ r[0];
        logic [15:0] x = r >> 1;
        return fb ? (x ^ 16'h8408) : x;
    endfunction

    // {feed, bit} that the engine should present before the coming edge
    function automatic logic [1:0] peek();
        logic [15:0] w;
        int n;
        if (mq.size() != 0) return {(m_kind == 2) && m_incl, mq[0]};
        if (!tx_en) return 2'b01;
        if (m_full) begin n = mk_data(m_byte, m_cfg, w); return {m_cfg[6], w[0]}; end
        if (!m_eom) return {1'b0, crc_rem[0]};
        n = mk_sync(m_cfg, m_sync, w);
        return {1'b0, w[0]};
    endfunction

    always @(posedge clk) begin
        logic [15:0] w;
        int n;
        bit b, f, set, was_full, old_preset;
        if (!rst_n) begin
            mq.delete();
            m_kind = 0; m_incl = 0; m_full = 0; m_eom = 1; m_irq = 0; m_txd = 1; m_preset = 0;
            m_byte = '0; m_cfg = '0; m_sync = '0;
            crc_rem <= '0;
        end else begin
            set = 0; was_full = m_full; old_preset = m_preset;
            if (mq.size() != 0) begin
                b = mq.pop_front(); f = (m_kind == 2) && m_incl;
            end else if (!tx_en) begin
                b = 1; f = 0; m_kind = 0;
            end else if (m_full) begin
                n = mk_data(m_byte, m_cfg, w);
                for (int i = 0; i < n; i++) mq.push_back(w[i]);
                m_incl = m_cfg[6]; m_full = 0; m_kind = 2;
                b = mq.pop_front(); f = m_incl;
            end else if (!m_eom) begin
                for (int i = 0; i < 16; i++) mq.push_back(crc_rem[i]);
                m_kind = 3; set = 1;
                b = mq.pop_front(); f = 0;
            end else begin
                n = mk_sync(m_cfg, m_sync, w);
                for (int i = 0; i < n; i++) mq.push_back(w[i]);
                m_kind = 1;
                b = mq.pop_front(); f = 0;
            end
            m_txd = b;
            m_irq = set;
            if (data_wr && !was_full) begin m_full = 1; m_byte = data_wdata; end
            if (cfg_wr) m_cfg = cfg_wdata;
            if (sync_wr) m_sync = sync_wdata;
            m_preset = cmd_wr && cmd_code == 2'b01;
            if (cmd_wr && cmd_code == 2'b10 && !set) m_eom = 0;
            if (set) m_eom = 1;
            // stand-in CRC unit, attached to the engine's preset and feed outputs
            if (old_preset) crc_rem <= 16'hFFFF;
            else if (f)     crc_rem <= crc_step(crc_rem, b);
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [1:0] p;
        #5;
        if (started && rst_n && !done) begin
            p = peek();
            chk(txd == m_txd, tag, "txd", int'(txd), int'(m_txd));
            chk(buf_empty == !m_full, "R12", "buf_empty", int'(buf_empty), int'(!m_full));
            chk(eom_flag == m_eom, "R8", "eom_flag", int'(eom_flag), int'(m_eom));
            chk(stat_irq == m_irq, "R7", "stat_irq", int'(stat_irq), int'(m_irq));
            chk(crc_preset == m_preset, "R10", "crc_preset", int'(crc_preset), int'(m_preset));
            chk(crc_feed == p[1], "R9", "crc_feed", int'(crc_feed), int'(p[1]));
            if (p[1]) chk(crc_din == p[0], "R9", "crc_din", int'(crc_din), int'(p[0]));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic w_cfg(input logic [6:0] v);
        cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
    endtask
    task automatic w_sync(input logic [15:0] v);
        sync_wr = 1; sync_wdata = v; @(negedge clk); sync_wr = 0;
    endtask
    task automatic w_cmd(input logic [1:0] c);
        cmd_wr = 1; cmd_code = c; @(negedge clk); cmd_wr = 0; cmd_code = 2'b00;
    endtask
    task automatic w_raw(input logic [7:0] v);
        data_wr = 1; data_wdata = v; @(negedge clk); data_wr = 0;
    endtask
    task automatic w_data(input logic [7:0] v);
        while (m_full) @(negedge clk);
        w_raw(v);
    endtask
    task automatic drain();
        while (m_full || mq.size() != 0) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #6;
        chk(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
        chk(buf_empty == 1'b1, "R1", "reset buf_empty", int'(buf_empty), 1);
        chk(eom_flag == 1'b1, "R1", "reset eom_flag", int'(eom_flag), 1);
        chk(stat_irq == 1'b0, "R1", "reset stat_irq", int'(stat_irq), 0);
        chk(crc_preset == 1'b0, "R1", "reset crc_preset", int'(crc_preset), 0);
        started = 1;
        @(negedge clk);

        tag = "R2";                                  // disabled line stays at mark
        idle(6);

        tag = "R6";                                  // sync fill variants
        w_sync(16'h3C96);
        tx_en = 1;
        idle(20);
        w_cfg(7'h10); idle(40);                      // 16-bit
        w_cfg(7'h20); idle(20);                      // 6-bit
        w_cfg(7'h30); idle(20);                      // code 11 behaves as 8-bit

        tag = "R3";                                  // 8-bit chars, CRC included
        w_cfg(7'h43);
        w_cmd(2'b01);                                // R10 preset
        w_data(8'hA7);
        w_cmd(2'b10);                                // R8 clear latch
        w_data(8'h5E);
        w_data(8'hFF);
        tag = "R7";                                  // underrun appends CRC, then sync
        idle(50);

        tag = "R5";                                  // parity, 7-bit even then 6-bit odd
        w_cfg(7'h4E);
        w_cmd(2'b01);
        w_data(8'hD5);
        w_cmd(2'b10);
        w_data(8'h80);
        w_cfg(7'h45);
        w_data(8'hF3);
        w_data(8'h00);
        idle(45);

        tag = "R4";                                  // variable short characters
        w_cfg(7'h00);
        w_data(8'h1B);
        w_data(8'h9F);
        w_data(8'hDA);
        w_data(8'hE6);
        w_data(8'hF1);
        w_data(8'hFF);
        w_cfg(7'h04);                                // short chars with odd parity
        w_data(8'hC5);
        w_data(8'hF0);
        idle(20);

        tag = "R9";                                  // inclusion sampled at transfer
        w_cfg(7'h43);
        w_cmd(2'b01);
        w_data(8'h3C);
        w_cmd(2'b10);
        w_data(8'h99);                               // waits while 0x3C shifts
        w_cfg(7'h03);                                // before 0x99 moves: excluded
        w_data(8'h6B);
        w_cfg(7'h43);                                // before 0x6B moves: included
        w_data(8'h12);
        w_cfg(7'h03);                                // after 0x12 moved? no: before, excluded
        idle(50);

        tag = "R12";                                 // write to a full buffer is dropped
        w_cfg(7'h03);
        w_data(8'h11);
        w_raw(8'h22);
        w_raw(8'h33);
        idle(30);

        tag = "R11";                                 // disable mid data char
        w_data(8'h81);
        while (m_full) @(negedge clk);
        idle(2);
        tx_en = 0;
        idle(20);
        tx_en = 1;                                   // disable mid sync char
        idle(4);
        tx_en = 0;
        idle(20);
        tx_en = 1;                                   // disable mid CRC
        w_cmd(2'b10);
        idle(4);
        tx_en = 0;
        drain();
        idle(10);

        done = 1;
        summary();
        $finish;
    end
endmodule